// File: doc/BRIEF.md
# Weight-Stationary Systolic MAC Grid

This block is a two-dimensional grid of signed multiply-accumulate cells for matrix and convolution work. Input vectors enter on the left, one element per row, and march one cell to the right per clock. Weights and running sums travel down the columns. Each column's bottom cell emits a finished dot product, and every result carries its own valid flag.

Every cell has two weight registers. The passing register forms a shift chain that moves weights down the column whenever the shift control is high. The held register takes a copy of the passing register when the latch control is pulsed. A select control picks which of the two feeds the multiplier. With the held weight selected, a filter stays fixed in the grid while a fresh set of weights is shifted into the passing chain behind it. This lets one filter serve many input vectors while the next filter loads.

The row inputs are skewed: row r is presented r cycles after row 0. Because of this, column results leave the bottom edge one cycle apart per column. Running sums saturate at every row step instead of wrapping.

Top module: `wsmac_grid`

## Requirements
- R1: While reset is active and after its release, every column valid output is 0 and every column sum output is 0 until the first valid data reaches the bottom row.
- R2: If row 0's element of a vector is sampled at clock edge E, and row r's element at edge E+r, then column c presents the sum over all rows of data times selected weight after edge E+ROWS-1+c, with its valid bit high for that one cycle.
- R3: Each running sum is clamped to the range from -2^(AW-1) to 2^(AW-1)-1 after each row's addition, taken in row order from top to bottom, so an overflow never wraps.
- R4: On each edge with the shift control high, the top cell of column c loads that column's weight input, and every lower cell loads the passing weight of the cell above. After ROWS shift edges, row r holds the value applied on shift edge number ROWS-1-r, counting from 0.
- R5: A one-cycle pulse on the latch control copies every cell's passing weight into its held weight on the same edge.
- R6: With the select control at 1 (held), shifting new values into the passing chain leaves the results unchanged.
- R7: With the select control at 0 (passing), each cell multiplies by its passing weight.
- R8: A row slot whose valid bit is low contributes no result, whatever data it carries. When no valid data arrives, column valid outputs stay low and column sum outputs keep their last value.
- R9: Vectors presented on back-to-back cycles produce results on back-to-back cycles in every column, one per clock.
- R10: Data, weights and sums are two's-complement signed values, so products of mixed sign accumulate correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_data_i | input | ROWS*DW | Signed data element per row; row r at bits r*DW upward |
| row_vld_i | input | ROWS | Valid bit per row slot |
| col_wgt_i | input | COLS*DW | Signed weight entering the top of each column; column c at bits c*DW upward |
| wgt_shift_i | input | 1 | Shift the passing weights down one row |
| wgt_latch_i | input | 1 | Copy passing weights into held weights |
| wgt_sel_i | input | 1 | Multiplier weight source: 0 passing, 1 held |
| col_psum_o | output | COLS*AW | Signed column result; column c at bits c*AW upward |
| col_vld_o | output | COLS | Result valid per column |

## Verification
The first pattern is a single vector of full-range random values against random weights. It checks the dot product and, through the first-valid cycle in each column, the one-cycle-per-column skew. A burst of back-to-back vectors separates true one-per-clock throughput from designs that stall, and a burst with invalid slots carrying junk data separates valid gating from designs that still accumulate. A sequence of shifting new weights under held select, then switching to passing select, then latching tells the two weight registers apart and confirms shift positions. Saturating patterns with an intermediate overflow followed by a recovery show whether the clamp is applied at each row step or only at the end.

// File: rtl/wsmac_pkg.sv
`timescale 1ns/1ps
package wsmac_pkg;
  // Source of the multiplier weight inside a cell.
  typedef enum logic {
    WSRC_PASS = 1'b0,
    WSRC_HELD = 1'b1
  } wsrc_e;

  localparam int unsigned DW_DEFAULT = 8;
  localparam int unsigned AW_DEFAULT = 24;
endpackage

// File: rtl/wsmac_sat_add.sv
`timescale 1ns/1ps
// Signed adder that clamps instead of wrapping.
module wsmac_sat_add #(
  parameter int unsigned AW = 24,
  parameter int unsigned BW = 16
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [BW-1:0] b_i,
  output logic signed [AW-1:0] y_o
);
  localparam logic signed [AW-1:0] SMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] SMIN = {1'b1, {(AW-1){1'b0}}};

  logic signed [AW:0] full;
  logic               ovf;

  always_comb begin
    full = (AW+1)'(a_i) + (AW+1)'(b_i);
    ovf  = full[AW] ^ full[AW-1];
    if (ovf) y_o = full[AW] ? SMIN : SMAX;
    else     y_o = full[AW-1:0];
    // Operands of one sign never yield a result of the other sign (R3).
    p_no_wrap_r3: assert ((a_i[AW-1] | b_i[BW-1] | ~y_o[AW-1]) &&
                          (~a_i[AW-1] | ~b_i[BW-1] | y_o[AW-1]));
  end
endmodule

// File: rtl/wsmac_pe.sv
`timescale 1ns/1ps
// One grid cell: rightward data path, downward weight and sum paths.
module wsmac_pe
  import wsmac_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] d_i,
  input  logic                 dv_i,
  input  logic signed [DW-1:0] w_i,
  input  logic signed [AW-1:0] ps_i,
  input  logic                 shift_i,
  input  logic                 latch_i,
  input  logic                 sel_i,
  output logic signed [DW-1:0] d_o,
  output logic                 dv_o,
  output logic signed [DW-1:0] w_o,
  output logic signed [AW-1:0] ps_o
);
  localparam int unsigned PW = 2 * DW;

  logic signed [DW-1:0] d_q, d_d;
  logic                 dv_q;
  logic signed [DW-1:0] wp_q, wp_d;
  logic signed [DW-1:0] wh_q, wh_d;
  logic signed [DW-1:0] w_eff;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] s_q, s_d, s_new;

  // Next-state logic with explicit enables.
  always_comb begin
    w_eff = (wsrc_e'(sel_i) == WSRC_HELD) ? wh_q : wp_q;
    prod  = PW'(d_i) * PW'(w_eff);
    d_d   = dv_i    ? d_i   : d_q;
    wp_d  = shift_i ? w_i   : wp_q;
    wh_d  = latch_i ? wp_q  : wh_q;
    s_d   = dv_i    ? s_new : s_q;
  end

  wsmac_sat_add #(.AW(AW), .BW(PW)) u_add (
    .a_i (ps_i),
    .b_i (prod),
    .y_o (s_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q  <= '0;
      dv_q <= 1'b0;
      wp_q <= '0;
      wh_q <= '0;
      s_q  <= '0;
    end else begin
      d_q  <= d_d;
      dv_q <= dv_i;
      wp_q <= wp_d;
      wh_q <= wh_d;
      s_q  <= s_d;
    end
  end

  assign d_o  = d_q;
  assign dv_o = dv_q;
  assign w_o  = wp_q;
  assign ps_o = s_q;

  // A latch pulse moves the passing weight into the held weight (R5).
  p_latch_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (wh_q == $past(wp_q)));

  // An empty slot leaves the running sum untouched (R8).
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dv_i |=> $stable(s_q));
endmodule

// File: rtl/wsmac_grid.sv
`timescale 1ns/1ps
// Weight-stationary systolic multiply-accumulate grid.
module wsmac_grid
  import wsmac_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 8,
  parameter int unsigned DW   = DW_DEFAULT,
  parameter int unsigned AW   = AW_DEFAULT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ROWS*DW-1:0]   row_data_i,
  input  logic [ROWS-1:0]      row_vld_i,
  input  logic [COLS*DW-1:0]   col_wgt_i,
  input  logic                 wgt_shift_i,
  input  logic                 wgt_latch_i,
  input  logic                 wgt_sel_i,
  output logic [COLS*AW-1:0]   col_psum_o,
  output logic [COLS-1:0]      col_vld_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // Interconnect: horizontal data/valid, vertical weight/sum.
  logic signed [DW-1:0] dat [ROWS][COLS+1];
  logic                 dvl [ROWS][COLS+1];
  logic signed [DW-1:0] wgt [ROWS+1][COLS];
  logic signed [AW-1:0] psm [ROWS+1][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_left
    assign dat[r][0] = row_data_i[r*DW +: DW];
    assign dvl[r][0] = row_vld_i[r];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_top
    assign wgt[0][c] = col_wgt_i[c*DW +: DW];
    assign psm[0][c] = '0;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      wsmac_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk_i   (clk_i),
        .rst_ni  (rst_sync_q),
        .d_i     (dat[r][c]),
        .dv_i    (dvl[r][c]),
        .w_i     (wgt[r][c]),
        .ps_i    (psm[r][c]),
        .shift_i (wgt_shift_i),
        .latch_i (wgt_latch_i),
        .sel_i   (wgt_sel_i),
        .d_o     (dat[r][c+1]),
        .dv_o    (dvl[r][c+1]),
        .w_o     (wgt[r+1][c]),
        .ps_o    (psm[r+1][c])
      );

      // Passing weights step down exactly one row per shift edge (R4).
      p_shift_step_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
        wgt_shift_i |=> (wgt[r+1][c] == $past(wgt[r][c])));
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_out
    assign col_psum_o[c*AW +: AW] = psm[ROWS][c];
    // A bottom-row sum is valid when its row slot was valid on entry.
    assign col_vld_o[c]           = dvl[ROWS-1][c+1];

    if (c > 0) begin : g_skew
      // Each column lags its left neighbour by exactly one cycle (R2).
      p_col_skew_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
        col_vld_o[c] == $past(col_vld_o[c-1]));
    end
  end
endmodule

// File: tb/wsmac_grid_bench.sv
`timescale 1ns/1ps
module wsmac_grid_bench;
  localparam int R  = 8;
  localparam int C  = 8;
  localparam int DW = 8;
  localparam int AW = 16;  // narrow sums so saturation is reachable

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic [R*DW-1:0]  row_data;
  logic [R-1:0]     row_vld;
  logic [C*DW-1:0]  col_wgt;
  logic             shift, latch, sel;
  logic [C*AW-1:0]  psum;
  logic [C-1:0]     vld;

  wsmac_grid #(.ROWS(R), .COLS(C), .DW(DW), .AW(AW)) u_wsmac_grid (
    .clk_i(clk), .rst_ni(rst_n), .row_data_i(row_data), .row_vld_i(row_vld),
    .col_wgt_i(col_wgt), .wgt_shift_i(shift), .wgt_latch_i(latch),
    .wgt_sel_i(sel), .col_psum_o(psum), .col_vld_o(vld)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state.
  int    wnew    [R][C];
  int    wpass_m [R][C];
  int    whold_m [R][C];
  bit    sel_m;
  int    vec     [64][R];
  bit    vok     [64];
  int    exp_mem [C][1024];
  int    wp [C];
  int    rp [C];
  int    nseen [C];
  int    first_cyc [C];
  int    last_cyc [C];
  int    burst_c0;
  string req = "R1";

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, expv, cyc);
    end
  endtask

  function automatic int sat(input int v);
    int lo, hi;
    lo = -(1 <<< (AW-1));
    hi = (1 <<< (AW-1)) - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int weff(input int r, input int c);
    return sel_m ? whold_m[r][c] : wpass_m[r][c];
  endfunction

  // Output monitor: compares every valid result in column order.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < C; c++) begin
        if (vld[c]) begin
          int act;
          act = int'($signed(psum[c*AW +: AW]));
          if (rp[c] < wp[c]) chk(act == exp_mem[c][rp[c]], req, act, exp_mem[c][rp[c]]);
          else               chk(1'b0, req, act, -999999);
          rp[c]++;
          if (nseen[c] == 0) first_cyc[c] = cyc;
          last_cyc[c] = cyc;
          nseen[c]++;
        end
      end
    end
  end

  task automatic rand_w();
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++)
        wnew[r][c] = int'($urandom_range(0, 255)) - 128;
  endtask

  task automatic rand_vec(input int n);
    for (int i = 0; i < n; i++) begin
      vok[i] = 1'b1;
      for (int r = 0; r < R; r++) vec[i][r] = int'($urandom_range(0, 255)) - 128;
    end
  endtask

  task automatic shift_in();
    for (int k = 0; k < R; k++) begin
      @(negedge clk);
      shift = 1'b1;
      for (int c = 0; c < C; c++) col_wgt[c*DW +: DW] = DW'(wnew[R-1-k][c]);
    end
    @(negedge clk);
    shift = 1'b0;
    wpass_m = wnew;
  endtask

  task automatic latch_now();
    @(negedge clk); latch = 1'b1;
    @(negedge clk); latch = 1'b0;
    whold_m = wpass_m;
  endtask

  task automatic set_sel(input bit b);
    @(negedge clk); sel = b;
    sel_m = b;
  endtask

  // Drives n skewed vector slots and waits for the grid to drain.
  task automatic run_burst(input int n, input string rq);
    req = rq;
    for (int c = 0; c < C; c++) nseen[c] = 0;
    for (int i = 0; i < n; i++) begin
      if (vok[i]) begin
        for (int c = 0; c < C; c++) begin
          int acc;
          acc = 0;
          for (int r = 0; r < R; r++) acc = sat(acc + vec[i][r] * weff(r, c));
          exp_mem[c][wp[c]] = acc;
          wp[c]++;
        end
      end
    end
    for (int t = 0; t < n + R - 1; t++) begin
      @(negedge clk);
      if (t == 0) burst_c0 = cyc;
      for (int r = 0; r < R; r++) begin
        int idx;
        idx = t - r;
        if (idx >= 0 && idx < n && vok[idx]) begin
          row_data[r*DW +: DW] = DW'(vec[idx][r]);
          row_vld[r] = 1'b1;
        end else begin
          row_data[r*DW +: DW] = 8'h5a;
          row_vld[r] = 1'b0;
        end
      end
    end
    @(negedge clk);
    row_vld = '0;
    repeat (R + C + 2) @(negedge clk);
    for (int c = 0; c < C; c++) chk(rp[c] == wp[c], rq, rp[c], wp[c]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; row_data = '0; row_vld = '0; col_wgt = '0;
    shift = 1'b0; latch = 1'b0; sel = 1'b0; sel_m = 1'b0;
    for (int c = 0; c < C; c++) begin wp[c] = 0; rp[c] = 0; nseen[c] = 0; end
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin wpass_m[r][c] = 0; whold_m[r][c] = 0; end
    repeat (3) @(negedge clk);
    chk(vld == '0, "R1", int'(vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(vld == '0, "R1", int'(vld), 0);
    chk(psum == '0, "R1", int'(psum[AW-1:0]), 0);
  endtask

  // Single vector: value and column skew.
  task automatic t_basic();
    rand_w(); shift_in(); latch_now(); set_sel(1'b1);
    rand_vec(1);
    run_burst(1, "R2");
    for (int c = 0; c < C; c++) chk(first_cyc[c] == burst_c0 + R + c, "R2", first_cyc[c], burst_c0 + R + c);
  endtask

  task automatic t_stream();
    rand_vec(20);
    run_burst(20, "R9");
    for (int c = 0; c < C; c++) begin
      chk(nseen[c] == 20, "R9", nseen[c], 20);
      chk(last_cyc[c] - first_cyc[c] + 1 == 20, "R9", last_cyc[c] - first_cyc[c] + 1, 20);
    end
  endtask

  task automatic t_bubble();
    int nv;
    rand_vec(10);
    vok[1] = 1'b0; vok[4] = 1'b0; vok[5] = 1'b0; vok[8] = 1'b0;
    nv = 6;
    run_burst(10, "R8");
    for (int c = 0; c < C; c++) begin
      chk(nseen[c] == nv, "R8", nseen[c], nv);
      chk(vld[c] == 1'b0, "R8", int'(vld[c]), 0);
      chk(int'($signed(psum[c*AW +: AW])) == exp_mem[c][wp[c]-1], "R8",
          int'($signed(psum[c*AW +: AW])), exp_mem[c][wp[c]-1]);
    end
  endtask

  // Held select: new passing weights must not matter.
  task automatic t_held();
    rand_w(); shift_in();
    rand_vec(6);
    run_burst(6, "R6");
  endtask

  // Passing select: uses the newly shifted weights in their rows.
  task automatic t_pass();
    set_sel(1'b0);
    rand_vec(6);
    run_burst(6, "R4 R7");
  endtask

  task automatic t_latch();
    latch_now(); set_sel(1'b1);
    rand_w(); shift_in();
    rand_vec(6);
    run_burst(6, "R5");
  endtask

  task automatic t_sat();
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) wnew[r][c] = -128;
    shift_in(); latch_now();
    for (int r = 0; r < R; r++) begin
      vec[0][r] = -128;
      vec[1][r] = 127;
      vec[2][r] = (r < 4) ? -128 : 127;
    end
    vok[0] = 1'b1; vok[1] = 1'b1; vok[2] = 1'b1;
    run_burst(3, "R3");
    chk(exp_mem[0][wp[0]-3] == 32767,  "R3", exp_mem[0][wp[0]-3], 32767);
    chk(exp_mem[0][wp[0]-2] == -32768, "R3", exp_mem[0][wp[0]-2], -32768);
  endtask

  task automatic t_signed();
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) wnew[r][c] = (c % 2 == 0) ? -3 : 5;
    shift_in(); latch_now();
    for (int r = 0; r < R; r++) begin vec[0][r] = r - 4; vec[1][r] = -1; end
    vok[0] = 1'b1; vok[1] = 1'b1;
    run_burst(2, "R10");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stream();
    t_bubble();
    t_held();
    t_pass();
    t_latch();
    t_sat();
    t_signed();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule